// File: doc/BRIEF.md
# Differential Manchester Bit Recovery with Counter Hold-off

This block recovers data from a differential Manchester (bi-phase) line that a fast system clock oversamples. The line first passes through a synchroniser. A transition detector compares each synchronised sample with the sample before it. A detected transition may fire a digital one-shot, which is a down-counter. While the one-shot is running it does not restart, and it runs for three quarters of a bit period. Cell-boundary transitions always fall inside that window, so within a few bits the block fires only on mid-cell transitions. Each firing is the recovered bit clock.

The bit period, counted in system clocks, comes from a separate rate estimator together with a valid flag. Rates from slow to fast are handled without any configuration change, because the window length follows the supplied period at run time. At each firing the block keeps the line level from just before the edge, which is the first-half level of the cell. The bit is 1 when that level differs from the one kept at the previous firing and 0 when it matches. The first firing after reset, and the first after the period changes or becomes invalid, yields no bit because there is no earlier level to compare with.

Top module: `dman_oneshot_rx`

## Requirements
- R1: During and after reset, with no line activity, `bit_vld_o` and `bit_o` are both 0.
- R2: A strobe caused by a line transition first applied in cycle j appears on `bit_vld_o` in cycle j+3. Two cycles are synchroniser latency and one is the registered output.
- R3: Rising and falling transitions of the line are equally able to fire the one-shot.
- R4: After a firing, transitions during the next floor(3*P/4) cycles are ignored, where P is `period_i`. A transition one cycle later fires again.
- R5: From a start where the first firing lands on a cell boundary, the block fires only on mid-cell transitions from the fourth bit onward, given that bits 1 to 3 are ones.
- R6: The decoded bit is 0 when the first-half level of the cell equals that of the previously decoded cell, and 1 when it differs.
- R7: No firing and no strobe occur while `period_ok_i` is 0 or `period_i` is 0.
- R8: The first firing after reset, or after `period_i` changes or is invalid, produces no strobe.
- R9: Once locked, exactly one strobe occurs per bit cell for every even bit period from 6 to 40 clocks, with no strobe at any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Raw differential Manchester line, asynchronous to clk |
| period_i | input | PERIOD_W | Bit period in system clocks, from the rate estimator |
| period_ok_i | input | 1 | Marks `period_i` as usable |
| bit_vld_o | output | 1 | One-cycle strobe for a recovered bit |
| bit_o | output | 1 | Recovered bit; holds its value between strobes |

## Verification
The hardest situation to reach from the ports is a start where the one-shot first latches onto a cell boundary rather than a mid-cell edge. The block then has to walk itself onto the mid-cell edges, which it can do only when a one-bit removes a boundary transition. The stimulus creates this by making the first cell's opening level differ from the idle level, so the first firing is the boundary edge, and by forcing ones into the next bits. Strobes are then required at exact mid-cell cycles from the fourth bit on. A separate hand-placed edge pair, one cycle inside the window and one cycle past it, pins the window length.

// File: rtl/dman_pkg.sv
package dman_pkg;

    localparam int unsigned DM_SYNC_DEPTH = 2;
    localparam int unsigned DM_PERIOD_W   = 12;

    typedef struct packed {
        logic have_prev;
        logic prev_lvl;
        logic vld;
        logic bit_v;
    } dec_state_t;

endpackage

// File: rtl/dman_line_sync.sv
module dman_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_before_o,
    output logic edge_o
);
    localparam int unsigned CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("dman_line_sync needs at least two stages");
        end
    endgenerate

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    // newest synchronised sample vs the one before it
    assign edge_o       = chain_q[CHAIN_W-1] ^ chain_q[CHAIN_W-2];
    assign lvl_before_o = chain_q[CHAIN_W-1];
endmodule

// File: rtl/dman_holdoff.sv
module dman_holdoff #(
    parameter int unsigned PW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          edge_i,
    input  logic [PW-1:0] period_i,
    input  logic          period_ok_i,
    output logic          trig_o,
    output logic          fresh_o
);
    localparam int unsigned XW = PW + 2;

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic [PW-1:0] per;
    } hold_state_t;

    hold_state_t   st_d, st_q;
    logic [XW-1:0] triple;
    logic [PW-1:0] hold_len;
    logic          usable;

    always_comb begin
        triple   = ({2'b00, period_i} << 1) + {2'b00, period_i};
        hold_len = triple[XW-1:2];
        usable   = period_ok_i && (period_i != '0);
        trig_o   = edge_i && usable && (st_q.cnt == '0);
        fresh_o  = !usable || (period_i != st_q.per);

        st_d     = st_q;
        st_d.per = period_i;
        if (!usable) begin
            st_d.cnt = '0;
        end else if (trig_o) begin
            st_d.cnt = hold_len;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dman_bit_decide.sv
module dman_bit_decide
    import dman_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic fresh_i,
    input  logic lvl_before_i,
    output logic vld_o,
    output logic bit_o
);
    dec_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (trig_i) begin
            st_d.vld       = st_q.have_prev && !fresh_i;
            st_d.bit_v     = (lvl_before_i != st_q.prev_lvl);
            st_d.prev_lvl  = lvl_before_i;
            st_d.have_prev = 1'b1;
        end else if (fresh_i) begin
            st_d.have_prev = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign bit_o = st_q.bit_v;
endmodule

// File: rtl/dman_oneshot_rx.sv
module dman_oneshot_rx #(
    parameter int unsigned PERIOD_W    = dman_pkg::DM_PERIOD_W,
    parameter int unsigned SYNC_STAGES = dman_pkg::DM_SYNC_DEPTH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                period_ok_i,
    output logic                bit_vld_o,
    output logic                bit_o
);
    logic edge_w;
    logic lvl_before_w;
    logic trig_w;
    logic fresh_w;

    dman_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (line_i),
        .lvl_before_o (lvl_before_w),
        .edge_o       (edge_w)
    );

    dman_holdoff #(.PW(PERIOD_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_i      (edge_w),
        .period_i    (period_i),
        .period_ok_i (period_ok_i),
        .trig_o      (trig_w),
        .fresh_o     (fresh_w)
    );

    dman_bit_decide u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_i       (trig_w),
        .fresh_i      (fresh_w),
        .lvl_before_i (lvl_before_w),
        .vld_o        (bit_vld_o),
        .bit_o        (bit_o)
    );
endmodule

// File: rtl/dman_oneshot_rx_chk.sv
module dman_oneshot_rx_chk #(
    parameter int unsigned PW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic [PW-1:0] period_i,
    input logic          period_ok_i,
    input logic          bit_vld_i,
    input logic          bit_i,
    input logic          edge_i
);
    localparam int unsigned XW = PW + 2;

    logic [PW:0]   gap_q;
    logic          seen_q;
    logic          steady_q;
    logic [PW-1:0] per_q;
    logic [XW-1:0] triple;
    logic [PW-1:0] win;

    always_comb begin
        triple = ({2'b00, period_i} << 1) + {2'b00, period_i};
        win    = triple[XW-1:2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q    <= '0;
            seen_q   <= 1'b0;
            steady_q <= 1'b0;
            per_q    <= '0;
        end else begin
            per_q <= period_i;
            if (bit_vld_i) begin
                gap_q    <= '0;
                seen_q   <= 1'b1;
                steady_q <= 1'b1;
            end else begin
                if (gap_q != {(PW+1){1'b1}}) gap_q <= gap_q + 1'b1;
                if (period_i != per_q || !period_ok_i) steady_q <= 1'b0;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !bit_vld_i && !bit_i); // R1

    AST_STROBE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld_i |-> $past(edge_i)); // R2

    AST_GAP_COVERS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld_i && seen_q && steady_q && period_i == per_q) |-> (gap_q >= {1'b0, win})); // R4

    AST_INVALID_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !period_ok_i |=> !bit_vld_i); // R7

    AST_ZERO_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i == '0) |=> !bit_vld_i); // R7

    AST_STABLE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld_i |-> $past(period_i) == $past(period_i, 2)); // R8
endmodule

bind dman_oneshot_rx dman_oneshot_rx_chk #(.PW(PERIOD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .period_i    (period_i),
    .period_ok_i (period_ok_i),
    .bit_vld_i   (bit_vld_o),
    .bit_i       (bit_o),
    .edge_i      (edge_w)
);

// File: tb/dman_oneshot_rx_bench.sv
module dman_oneshot_rx_bench;
    localparam int PW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_i = 1'b0;
    logic [PW-1:0] period_i = '0;
    logic          period_ok_i = 1'b0;
    logic          bit_vld_o;
    logic          bit_o;

    always #10 clk = ~clk;

    dman_oneshot_rx #(.PERIOD_W(PW)) u_dman_oneshot_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line_i),
        .period_i    (period_i),
        .period_ok_i (period_ok_i),
        .bit_vld_o   (bit_vld_o),
        .bit_o       (bit_o)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic        cur = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic        bits [64];
    logic        fl [64];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input logic lv);
        @(negedge clk);
        line_i = lv;
    endtask

    // pl: line bit period, pc: configured period, ok: valid flag, mis: start on a boundary
    task automatic run_stream(input int pl, input int pc, input bit ok, input bit mis, input int n);
        int  kstart;
        bit  live;
        period_i    = pc[PW-1:0];
        period_ok_i = ok;
        repeat (40) drive(cur);
        for (int k = 0; k < n; k++) begin
            lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bits[k] = lfsr[0];
        end
        if (mis) begin
            bits[1] = 1'b1; bits[2] = 1'b1; bits[3] = 1'b1;
        end
        fl[0] = mis ? ~cur : cur;
        for (int k = 1; k < n; k++) fl[k] = bits[k] ? ~fl[k-1] : fl[k-1];
        kstart = mis ? 4 : 0;
        live   = ok && (pc != 0);
        for (int idx = 0; idx < n * pl + 4; idx++) begin
            int   kc;
            int   pos;
            int   k;
            int   r;
            logic lv;
            kc = idx / pl;
            if (kc >= n) lv = ~fl[n-1];
            else         lv = ((idx % pl) >= pl / 2) ? ~fl[kc] : fl[kc];
            drive(lv);
            pos = idx - 3;
            if (pos >= kstart * pl) begin
                k = pos / pl;
                r = pos % pl;
                if (!live) begin
                    check(bit_vld_o == 1'b0, "R7 strobe while period unusable", int'(bit_vld_o), 0);
                end else if (k < n && r == pl / 2 && k >= 1 && k >= kstart) begin
                    if (mis) check(bit_vld_o == 1'b1, "R5 locked mid-cell strobe", int'(bit_vld_o), 1);
                    else     check(bit_vld_o == 1'b1, "R2 R3 mid-cell strobe timing", int'(bit_vld_o), 1);
                    check(bit_o == bits[k], "R6 decoded bit", int'(bit_o), int'(bits[k]));
                end else if (k == 0 && r == pl / 2) begin
                    check(bit_vld_o == 1'b0, "R8 first firing gives no strobe", int'(bit_vld_o), 0);
                end else begin
                    check(bit_vld_o == 1'b0, "R9 no strobe off mid-cell", int'(bit_vld_o), 0);
                end
            end
        end
        cur = ~fl[n-1];
    endtask

    // edges at offsets 0, 12, 13 with P=16: window is 12 cycles
    task automatic window_edge_test();
        logic lv;
        period_i    = 12'd16;
        period_ok_i = 1'b1;
        repeat (40) drive(cur);
        for (int o = 0; o < 30; o++) begin
            lv = cur ^ (o >= 0) ^ (o >= 12) ^ (o >= 13);
            drive(lv);
            if (o == 3)  check(bit_vld_o == 1'b0, "R8 first firing after period change", int'(bit_vld_o), 0);
            if (o == 15) check(bit_vld_o == 1'b0, "R4 edge inside window ignored", int'(bit_vld_o), 0);
            if (o == 16) begin
                check(bit_vld_o == 1'b1, "R4 edge after window fires", int'(bit_vld_o), 1);
                check(bit_o == 1'b0, "R6 equal first-half levels give 0", int'(bit_o), 0);
            end
        end
        cur = ~cur;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(bit_vld_o == 1'b0, "R1 strobe low in reset", int'(bit_vld_o), 0);
        check(bit_o == 1'b0, "R1 bit low in reset", int'(bit_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(bit_vld_o == 1'b0, "R1 strobe low after reset", int'(bit_vld_o), 0);
        check(bit_o == 1'b0, "R1 bit low after reset", int'(bit_o), 0);

        for (int p = 6; p <= 40; p += 2) run_stream(p, p, 1'b1, 1'b0, 24);
        run_stream(20, 20, 1'b1, 1'b1, 24);
        run_stream(34, 34, 1'b1, 1'b1, 24);
        window_edge_test();
        run_stream(24, 24, 1'b0, 1'b0, 16);
        run_stream(24, 0, 1'b1, 1'b0, 16);
        run_stream(24, 24, 1'b1, 1'b0, 24);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule